// File: doc/BRIEF.md
# Register-Mapped I2C Bus Master

This block lets a host processor run an I2C bus one byte at a time through six byte-wide registers. The host picks a register with a small offset bus and uses single-cycle read and write strobes. The registers hold the own address, a clock divider, a control byte, a status byte, a data byte and a filter sampling rate. The block drives SCL and SDA only as open-drain pull-down enables. It reads SDA back to sample acknowledges and receive data. A level interrupt tells the host that a byte has finished.

Each bus byte starts from a host access to the data register. After a fresh cycle, the first data write in master mode is sent as an address byte, preceded by a START. Later writes go out as data bytes. In master receive mode, a read of the data register returns the byte held there and starts fetching the next one. The host controls STOP by clearing the master bit, and requests a repeated START with a control bit. While a byte or a STOP is in flight, the block reports itself busy and ignores data-register accesses.

Top module: `regI2cMaster`

## Requirements
- R1: After hard reset, status reads 0x81 and the own-address, divider, control, data and filter registers read 0x00. The interrupt is low and neither bus line is pulled low.
- R2: Registers sit at offsets 0x00 own address, 0x04 divider, 0x08 control, 0x0C status, 0x10 data and 0x14 filter. Writes keep value AND 0xFE for own address, AND 0x3F for the divider, AND 0xFC for control, AND 0xED for status, and the full byte for data and filter. Every other offset reads 0x00 and ignores writes.
- R3: A control write with bit 7 (enable) at 0 while the block is enabled does not store the value. It returns every register to its hard-reset value except own address, which keeps its contents, and it releases both bus lines.
- R4: A stored control value with bit 5 (master) at 1 sets status bit 5 (bus busy). With bit 5 at 0, it clears status bit 5 and, if an address byte has been sent, issues a STOP and starts a fresh cycle.
- R5: Data-register writes are ignored while control bit 7 is 0. In master mode, the first write of a cycle issues START and then sends the byte MSB first as a 7-bit address plus R/W in bit 0. Later writes are sent as data. SDA only changes while SCL is low.
- R6: When the acknowledge bit is ACK after an address or data byte, status bit 0 (received NACK) is cleared and status bits 7 (complete) and 1 (interrupt pending) are set. A NACK after an address sets bit 0 only and leaves the cycle fresh. A NACK after a data byte sets bit 0, issues a STOP and leaves the cycle fresh.
- R7: With control bits 7 and 5 at 1 and bit 4 (transmit) at 0, a data-register read returns the held byte and receives the next byte. The master drives ACK, or NACK when control bit 3 is 1. On completion the byte lands in the data register and status bits 7 and 1 are set.
- R8: A control write with bits 2 (repeated start) and 5 at 1 while a cycle is open starts a fresh cycle without a STOP and stores bit 2 as 0. The next data write then issues a repeated START and an address byte.
- R9: The interrupt output is 1 exactly when control bits 7 and 6 and status bit 1 are all 1. A status write clears status bit 1.
- R10: The busy output is 1 from a byte or STOP request until its effects are in the registers. Data-register writes and receive-launching reads made while busy are ignored.
- R11: If a status write lands in the same cycle as a byte completion, the written value is stored first and the completion flags are then applied on top of it.
- R12: Each SCL period inside a byte lasts 4 × (divider + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hard reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effect on data register) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed register |
| busy | output | 1 | A bus operation is in flight |
| irq | output | 1 | Level interrupt |
| sclLowEn | output | 1 | Pull SCL low when 1 |
| sdaLowEn | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | Resolved SDA line level |

## Verification
Two things can land on the status register in the same clock edge: a host status write and the completion of a byte. To force this, the bench holds a status write asserted on every cycle while the byte is in flight, so one of those writes always coincides with the completion edge. Afterwards the bench expects exactly the written value with the complete and pending flags added. Writing while busy is also tried: a second data write issued right behind the first must leave no trace on the bus or in the data register.

// File: rtl/i2cMstPkg.sv
package i2cMstPkg;
  localparam int OFF_OWN = 'h00;
  localparam int OFF_DIV = 'h04;
  localparam int OFF_CTL = 'h08;
  localparam int OFF_STS = 'h0C;
  localparam int OFF_DAT = 'h10;
  localparam int OFF_FLT = 'h14;

  localparam int C_EN   = 7;
  localparam int C_IEN  = 6;
  localparam int C_MSTA = 5;
  localparam int C_MTX  = 4;
  localparam int C_TXAK = 3;
  localparam int C_RSTA = 2;

  localparam int S_MCF  = 7;
  localparam int S_MBB  = 5;
  localparam int S_MIF  = 1;
  localparam int S_RXAK = 0;

  localparam logic [7:0] OWN_MASK = 8'hFE;
  localparam logic [7:0] CTL_MASK = 8'hFC;
  localparam logic [7:0] STS_MASK = 8'hED;
  localparam logic [7:0] STS_RST  = 8'h81;
  localparam logic [7:0] NO_CYCLE = 8'hFF;

  typedef enum logic [1:0] {K_ADDR, K_TX, K_RX} byteKind_t;
  typedef enum logic [1:0] {E_IDLE, E_START, E_BITS, E_STOP} engState_t;

  typedef struct packed {
    logic start;
    logic byteGo;
    logic stop;
    logic rxMode;
    logic nackBit;
    logic abort;
  } i2cCmd_t;
endpackage

// File: rtl/i2cMstBitEng.sv
module i2cMstBitEng
  import i2cMstPkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  i2cCmd_t          cmd,
  input  logic [7:0]       txByte,
  input  logic [DIV_W-1:0] divVal,
  input  logic             sdaIn,
  output logic             sclLowEn,
  output logic             sdaLowEn,
  output logic             busy,
  output logic             done,
  output logic             ackIn,
  output logic [7:0]       rxByte
);
  localparam int LAST_BIT = 8;

  engState_t        st;
  logic [DIV_W-1:0] qCnt;
  logic [1:0]       ph;
  logic [3:0]       bitIdx;
  logic [7:0]       sh;
  logic             sampBit, rxMode, nackBit, owned;
  logic             tick;

  assign tick   = (qCnt == divVal);
  assign busy   = (st != E_IDLE);
  assign rxByte = sh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= E_IDLE; qCnt <= '0; ph <= '0; bitIdx <= '0; sh <= '0;
      sampBit <= 1'b1; rxMode <= 1'b0; nackBit <= 1'b0; owned <= 1'b0;
      done <= 1'b0; ackIn <= 1'b1;
    end else begin
      done <= 1'b0;
      if (cmd.abort) begin
        st <= E_IDLE;
        owned <= 1'b0;
      end else if (st == E_IDLE) begin
        if (cmd.byteGo || cmd.stop) begin
          qCnt    <= '0;
          ph      <= '0;
          bitIdx  <= '0;
          sh      <= cmd.rxMode ? 8'hFF : txByte;
          rxMode  <= cmd.rxMode;
          nackBit <= cmd.nackBit;
          st      <= cmd.stop ? E_STOP : (cmd.start ? E_START : E_BITS);
        end
      end else begin
        qCnt <= tick ? '0 : qCnt + 1'b1;
        if (tick) begin
          ph <= ph + 2'd1;
          if (st == E_BITS && ph == 2'd2) begin
            if (bitIdx < 4'(LAST_BIT)) sampBit <= sdaIn;
            else                       ackIn   <= sdaIn;
          end
          if (ph == 2'd3) begin
            case (st)
              E_START: begin
                st    <= E_BITS;
                owned <= 1'b1;
              end
              E_BITS: begin
                if (bitIdx == 4'(LAST_BIT)) begin
                  st    <= E_IDLE;
                  done  <= 1'b1;
                  owned <= 1'b1;
                end else begin
                  sh     <= {sh[6:0], sampBit};
                  bitIdx <= bitIdx + 4'd1;
                end
              end
              E_STOP: begin
                st    <= E_IDLE;
                owned <= 1'b0;
              end
              default: st <= E_IDLE;
            endcase
          end
        end
      end
    end
  end

  // Line drive per state and quarter phase (1 = pull low)
  always_comb begin
    sclLowEn = 1'b0;
    sdaLowEn = 1'b0;
    case (st)
      E_IDLE:  sclLowEn = owned;
      E_START: begin
        sclLowEn = (ph == 2'd0) || (ph == 2'd3);
        sdaLowEn = (ph == 2'd2) || (ph == 2'd3);
      end
      E_BITS: begin
        sclLowEn = (ph == 2'd0) || (ph == 2'd3);
        if (bitIdx < 4'(LAST_BIT)) sdaLowEn = !rxMode && !sh[7];
        else                       sdaLowEn = rxMode && !nackBit;
      end
      E_STOP: begin
        sclLowEn = (ph == 2'd0);
        sdaLowEn = (ph == 2'd0) || (ph == 2'd1);
      end
      default: ;
    endcase
  end

  // R10: the controller never requests a new operation while one runs
  a_r10_cmd_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    (st != E_IDLE) |-> !(cmd.byteGo || cmd.stop));

  // R3: abort leaves the engine idle with SCL released
  a_r3_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmd.abort |=> (st == E_IDLE) && !sclLowEn && !sdaLowEn);

  // R5: SDA is steady while SCL is high during a bit
  a_r5_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (st == E_BITS && $past(st) == E_BITS && ph == 2'd2 && $past(ph) == 2'd2)
      |-> $stable(sdaLowEn));
endmodule

// File: rtl/i2cMstCtl.sv
module i2cMstCtl
  import i2cMstPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              busy,
  output logic              irq,
  output i2cCmd_t           cmd,
  output logic [7:0]        txByte,
  output logic [DIV_W-1:0]  divVal,
  input  logic              engBusy,
  input  logic              engDone,
  input  logic              engAckIn,
  input  logic [7:0]        engRxByte
);
  localparam logic [7:0] DIV_MASK = 8'((1 << DIV_W) - 1);

  logic [7:0] ownAdr, divReg, ctlReg, stsReg, datReg, fltReg, cycAdr;
  logic       stopPend;
  byteKind_t  byteKind;

  logic selOwn, selDiv, selCtl, selSts, selDat, selFlt;
  logic ctlWr, softRst, datWr, datRd, openXfer;
  logic [7:0] ctlNew, stsNext;
  logic masterNew, dropMaster, rstaKill, cmdValid;

  assign selOwn = (regAddr == ADDR_W'(OFF_OWN));
  assign selDiv = (regAddr == ADDR_W'(OFF_DIV));
  assign selCtl = (regAddr == ADDR_W'(OFF_CTL));
  assign selSts = (regAddr == ADDR_W'(OFF_STS));
  assign selDat = (regAddr == ADDR_W'(OFF_DAT));
  assign selFlt = (regAddr == ADDR_W'(OFF_FLT));

  assign cmdValid = |cmd;
  assign busy     = engBusy || engDone || stopPend || cmdValid;
  assign openXfer = (cycAdr != NO_CYCLE);

  assign ctlWr      = regWr && selCtl;
  assign softRst    = ctlWr && ctlReg[C_EN] && !regWdata[C_EN];
  assign ctlNew     = regWdata & CTL_MASK;
  assign masterNew  = ctlNew[C_MSTA];
  assign dropMaster = ctlWr && !softRst && !masterNew && openXfer;
  assign rstaKill   = ctlWr && !softRst && masterNew && ctlNew[C_RSTA] && openXfer;
  assign datWr      = regWr && selDat && ctlReg[C_EN] && !busy;
  assign datRd      = regRd && selDat && ctlReg[C_MSTA] && !ctlReg[C_MTX] && !busy;

  assign txByte = datReg;
  assign divVal = divReg[DIV_W-1:0];
  assign irq    = ctlReg[C_EN] && ctlReg[C_IEN] && stsReg[S_MIF];

  // Status merge: host write first, completion flags on top (R11)
  always_comb begin
    stsNext = stsReg;
    if (ctlWr && !softRst) stsNext[S_MBB] = masterNew;
    if (regWr && selSts)   stsNext = regWdata & STS_MASK;
    if (engDone) begin
      if (byteKind == K_RX || !engAckIn) begin
        stsNext[S_MCF] = 1'b1;
        stsNext[S_MIF] = 1'b1;
        if (byteKind != K_RX) stsNext[S_RXAK] = 1'b0;
      end else begin
        stsNext[S_RXAK] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownAdr <= '0; divReg <= '0; ctlReg <= '0; stsReg <= STS_RST;
      datReg <= '0; fltReg <= '0; cycAdr <= NO_CYCLE; stopPend <= 1'b0;
      byteKind <= K_ADDR; cmd <= '0;
    end else if (softRst) begin
      divReg <= '0; ctlReg <= '0; stsReg <= STS_RST; datReg <= '0;
      fltReg <= '0; cycAdr <= NO_CYCLE; stopPend <= 1'b0;
      cmd <= '0;
      cmd.abort <= 1'b1;
    end else begin
      cmd <= '0;
      stsReg <= stsNext;
      if (regWr && selOwn) ownAdr <= regWdata & OWN_MASK;
      if (regWr && selDiv) divReg <= regWdata & DIV_MASK;
      if (regWr && selFlt) fltReg <= regWdata;
      if (ctlWr) begin
        ctlReg <= ctlNew;
        if (rstaKill) ctlReg[C_RSTA] <= 1'b0;
        if (dropMaster || rstaKill) cycAdr <= NO_CYCLE;
      end
      if (stopPend && !engBusy && !engDone && !cmdValid) begin
        cmd.stop <= 1'b1;
        stopPend <= 1'b0;
      end
      if (dropMaster) stopPend <= 1'b1;
      if (datWr) begin
        datReg <= regWdata;
        if (ctlReg[C_MSTA]) begin
          cmd.byteGo <= 1'b1;
          cmd.start  <= !openXfer;
          byteKind   <= openXfer ? K_TX : K_ADDR;
        end
      end
      if (datRd) begin
        cmd.byteGo  <= 1'b1;
        cmd.rxMode  <= 1'b1;
        cmd.nackBit <= ctlReg[C_TXAK];
        byteKind    <= K_RX;
      end
      if (engDone) begin
        case (byteKind)
          K_ADDR: if (!engAckIn) cycAdr <= datReg;
          K_TX: if (engAckIn) begin
            stopPend <= 1'b1;
            cycAdr   <= NO_CYCLE;
          end
          default: datReg <= engRxByte;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (selOwn) regRdata = ownAdr;
    if (selDiv) regRdata = divReg;
    if (selCtl) regRdata = ctlReg;
    if (selSts) regRdata = stsReg;
    if (selDat) regRdata = datReg;
    if (selFlt) regRdata = fltReg;
  end

  // R9: any status write without a coinciding completion clears pending
  a_r9_sts_wr_clears_mif: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && selSts && !engDone) |=> !stsReg[S_MIF]);

  // R4: storing the master bit raises bus busy
  a_r4_master_sets_bb: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !softRst && regWdata[C_MSTA]) |=> stsReg[S_MBB]);

  // R8: repeated start on an open cycle self-clears and resets the cycle
  a_r8_rsta_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (rstaKill && !engDone) |=> !ctlReg[C_RSTA] && (cycAdr == NO_CYCLE));

  // R6: an address NACK flags received NACK and leaves the cycle fresh
  a_r6_addr_nack: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && byteKind == K_ADDR && engAckIn && !softRst)
      |=> stsReg[S_RXAK] && (cycAdr == NO_CYCLE));
endmodule

// File: rtl/regI2cMaster.sv
module regI2cMaster
  import i2cMstPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              busy,
  output logic              irq,
  output logic              sclLowEn,
  output logic              sdaLowEn,
  input  logic              sdaIn
);
  i2cCmd_t          cmd;
  logic [7:0]       txByte, rxByte;
  logic [DIV_W-1:0] divVal;
  logic             engBusy, engDone, engAckIn;

  i2cMstCtl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .irq(irq),
    .cmd(cmd), .txByte(txByte), .divVal(divVal), .engBusy(engBusy),
    .engDone(engDone), .engAckIn(engAckIn), .engRxByte(rxByte)
  );

  i2cMstBitEng #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txByte(txByte), .divVal(divVal),
    .sdaIn(sdaIn), .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn), .busy(engBusy),
    .done(engDone), .ackIn(engAckIn), .rxByte(rxByte)
  );
endmodule

// File: tb/regI2cMaster_tb.sv
module regI2cMaster_tb;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTL = 5'h08,
                            A_STS = 5'h0C, A_DAT = 5'h10, A_FLT = 5'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic busy, irq, sclLowEn, sdaLowEn;
  logic sDrv = 1'b0;
  wire  sclLine = !sclLowEn;
  wire  sdaLine = !(sdaLowEn || sDrv);

  int nTests = 0, nFails = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  regI2cMaster u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .irq(irq),
    .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn), .sdaIn(sdaLine)
  );

  // ---------------- target device model ----------------
  int sBit = 0;
  logic sActive = 0, sAddrPhase = 0, sReadMode = 0, sInAck = 0, sAccept = 0;
  logic [7:0] sShift = 0, sTx = 0, sRdNext = 8'hC3, sLastWr = 0;
  logic mAck = 1;
  int sStartCnt = 0, sStopCnt = 0, sWrCnt = 0;
  int lastRise = 0, risePeriod = 0;

  always @(negedge sdaLine) if (sclLine) begin
    sBit = 0; sAddrPhase = 1; sActive = 1; sInAck = 0; sDrv = 0;
    sStartCnt++;
  end
  always @(posedge sdaLine) if (sclLine) begin
    sActive = 0; sDrv = 0; sStopCnt++;
  end
  always @(posedge sclLine) begin
    risePeriod = cyc - lastRise;
    lastRise = cyc;
    if (sActive) begin
      if (sBit < 8) begin sShift = {sShift[6:0], sdaLine}; sBit++; end
      else mAck = sdaLine;
    end
  end
  always @(negedge sclLine) if (sActive) begin
    if (!sInAck && sBit == 8) begin
      sInAck = 1;
      if (sAddrPhase) begin
        sAccept = (sShift[7:1] == 7'h2A);
        sDrv = sAccept;
      end else if (!sReadMode) begin
        sLastWr = sShift; sWrCnt++;
        sDrv = (sShift != 8'hEE);
      end else sDrv = 0;
    end else if (sInAck) begin
      sInAck = 0; sBit = 0; sDrv = 0;
      if (sAddrPhase) begin
        sAddrPhase = 0; sReadMode = sShift[0];
        if (!sAccept) sActive = 0;
        else if (sReadMode) begin sTx = sRdNext; sRdNext += 8'h35; sDrv = !sTx[7]; end
      end else if (sReadMode && !mAck) begin
        sTx = sRdNext; sRdNext += 8'h35; sDrv = !sTx[7];
      end
    end else if (sReadMode && !sAddrPhase && sBit > 0 && sBit < 8) begin
      sDrv = !sTx[7-sBit];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk); regAddr = a; regWdata = v; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRd = 1; #1 v = regRdata;
    @(negedge clk); regRd = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check(0, "watchdog busy", n, 0);
  endtask

  function automatic logic [7:0] maskOf(input logic [AW-1:0] a);
    case (a)
      A_OWN: return 8'hFE;
      A_DIV: return 8'h3F;
      A_FLT: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #1_000_000;
    check(0, "watchdog global", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v, r, expRd;
    int st0, sp0, wc0;
    void'($urandom(32'h1C2A));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_STS, r); check(r == 8'h81, "R1 status reset", r, 8'h81);
    rd(A_CTL, r); check(r == 8'h00, "R1 control reset", r, 0);
    rd(A_DAT, r); check(r == 8'h00, "R1 data reset", r, 0);
    rd(A_OWN, r); check(r == 8'h00, "R1 own reset", r, 0);
    check(!irq && !sclLowEn && !sdaLowEn, "R1 pins idle", {irq, sclLowEn, sdaLowEn}, 0);

    // R2 masks with random values
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      a = (i % 3 == 0) ? A_OWN : (i % 3 == 1) ? A_DIV : A_FLT;
      v = 8'($urandom);
      wr(a, v); rd(a, r);
      check(r == (v & maskOf(a)), "R2 write mask", r, v & maskOf(a));
    end
    wr(5'h18, 8'hFF); rd(5'h18, r); check(r == 0, "R2 unmapped read", r, 0);
    rd(5'h02, r); check(r == 0, "R2 unmapped read2", r, 0);
    wr(A_OWN, 8'hFF); wr(A_DIV, 8'h15); wr(A_FLT, 8'hA5);
    wr(A_CTL, 8'hFF); rd(A_CTL, r); check(r == 8'hFC, "R2 control mask", r, 8'hFC);
    rd(A_STS, r); check(r == 8'hA1, "R4 master sets bus busy", r, 8'hA1);

    // R3 soft reset
    wr(A_CTL, 8'h00);
    rd(A_OWN, r); check(r == 8'hFE, "R3 own kept", r, 8'hFE);
    rd(A_DIV, r); check(r == 8'h00, "R3 divider cleared", r, 0);
    rd(A_FLT, r); check(r == 8'h00, "R3 filter cleared", r, 0);
    rd(A_STS, r); check(r == 8'h81, "R3 status reset", r, 8'h81);
    rd(A_CTL, r); check(r == 8'h00, "R3 control reset", r, 0);

    // R5 data write ignored while disabled
    wr(A_DAT, 8'h5A); @(negedge clk);
    rd(A_DAT, r); check(r == 0 && !busy && !sclLowEn, "R5 disabled write ignored", r, 0);

    // Address byte + R9 interrupt
    wr(A_CTL, 8'hF0);
    st0 = sStartCnt;
    wr(A_DAT, 8'h54); waitIdle();
    check(sStartCnt == st0 + 1, "R5 start before address", sStartCnt, st0 + 1);
    rd(A_STS, r); check(r == 8'hA2, "R6 address ack flags", r, 8'hA2);
    check(irq, "R9 irq raised", irq, 1);
    wr(A_STS, 8'h20); check(!irq, "R9 irq cleared by status write", irq, 0);

    // Random data bytes, alternating plain and same-cycle status writes
    for (int i = 0; i < 6; i++) begin
      v = 8'($urandom); if (v == 8'hEE) v = 8'h11;
      wc0 = sWrCnt;
      if (i == 2) wr(A_DIV, 8'h02);
      if (i % 2 == 0) begin
        wr(A_STS, 8'h20); wr(A_DAT, v); waitIdle();
        rd(A_STS, r); check(r == 8'hA2, "R6 data ack flags", r, 8'hA2);
      end else begin
        int n = 0;
        wr(A_DAT, v);
        regAddr = A_STS; regWdata = 8'h20; regWr = 1;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        regWr = 0;
        rd(A_STS, r); check(r == 8'hA2, "R11 completion over status write", r, 8'hA2);
      end
      check(sLastWr == v && sWrCnt == wc0 + 1, "R5 data byte on bus", sLastWr, v);
      if (i == 2) begin
        check(risePeriod == 12, "R12 scl period div=2", risePeriod, 12);
        wr(A_DIV, 8'h00);
      end
    end

    // R6 data NACK -> STOP, fresh cycle
    sp0 = sStopCnt;
    wr(A_STS, 8'h20); wr(A_DAT, 8'hEE); waitIdle();
    rd(A_STS, r); check(r == 8'h21, "R6 data nack flags", r, 8'h21);
    check(sStopCnt == sp0 + 1 && !sclLowEn && !sdaLowEn, "R6 stop after data nack", sStopCnt, sp0 + 1);
    st0 = sStartCnt;
    wr(A_DAT, 8'h54); waitIdle();
    check(sStartCnt == st0 + 1, "R6 next write is address", sStartCnt, st0 + 1);

    // R8 repeated start, then address NACK
    sp0 = sStopCnt; st0 = sStartCnt;
    wr(A_CTL, 8'hF4); rd(A_CTL, r); check(r == 8'hF0, "R8 rsta self-clears", r, 8'hF0);
    wr(A_STS, 8'h20); wr(A_DAT, 8'h60); waitIdle();
    check(sStartCnt == st0 + 1 && sStopCnt == sp0, "R8 repeated start no stop", sStopCnt, sp0);
    rd(A_STS, r); check(r == 8'h21, "R6 address nack flags", r, 8'h21);
    check(!irq, "R9 no irq on address nack", irq, 0);
    wr(A_DAT, 8'h54); waitIdle();
    check(sStartCnt == st0 + 2, "R6 address nack keeps fresh cycle", sStartCnt, st0 + 2);

    // R4 master clear -> STOP
    sp0 = sStopCnt;
    wr(A_CTL, 8'hD0); waitIdle();
    check(sStopCnt == sp0 + 1 && !sclLowEn, "R4 stop on master clear", sStopCnt, sp0 + 1);
    rd(A_STS, r); check(r[5] == 0, "R4 bus busy cleared", r, r & 8'hDF);

    // R10 data write while busy is dropped
    wr(A_CTL, 8'hF0);
    wc0 = sWrCnt; st0 = sStartCnt;
    wr(A_DAT, 8'h54);
    check(busy, "R10 busy asserted", busy, 1);
    wr(A_DAT, 8'h33); waitIdle();
    rd(A_DAT, r); check(r == 8'h54, "R10 write while busy ignored", r, 8'h54);
    check(sWrCnt == wc0 && sStartCnt == st0 + 1, "R10 no extra bus byte", sWrCnt, wc0);

    // R7 receive sequence
    wr(A_CTL, 8'hF4); wr(A_DAT, 8'h55); waitIdle();
    wr(A_CTL, 8'hE0);
    expRd = 8'hC3;
    rd(A_DAT, r); check(r == 8'h55, "R7 first read returns held byte", r, 8'h55);
    waitIdle();
    check(irq, "R7 irq after receive", irq, 1);
    wr(A_STS, 8'h20);
    rd(A_DAT, r); check(r == expRd, "R7 receive byte0", r, expRd);
    waitIdle();
    check(mAck == 0, "R7 master acks", mAck, 0);
    expRd += 8'h35;
    wr(A_CTL, 8'hE8);
    rd(A_DAT, r); check(r == expRd, "R7 receive byte1", r, expRd);
    waitIdle();
    check(mAck == 1, "R7 master nacks with txak", mAck, 1);
    expRd += 8'h35;
    rd(A_STS, r); check(r == 8'hA2, "R7 receive flags", r, 8'hA2);
    wr(A_CTL, 8'hC0); waitIdle();
    rd(A_DAT, r); @(negedge clk);
    check(r == expRd && !busy, "R7 last byte no relaunch", r, expRd);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule